// File: doc/BRIEF.md
# Serial Control Interface Master

This block sits on the host side of an audio codec and carries out single 16-bit register accesses over the codec's four-wire serial control port. The local side presents a one-cycle request that gives the direction (read or write), an 8-bit register address and, for writes, a 16-bit word. The block then waits until the codec's ready line is high. It opens the chip-select window and shifts out a 32-bit frame: an opcode byte, then the address byte, then a 16-bit data field. It closes the window after the last serial clock.

For a read, the block sends zeros during the data field and collects the 16 bits the codec returns on its serial output line. It presents them on `rd_data` together with a one-cycle `done` pulse. Writes also end with a `done` pulse. The serial clock comes from the system clock through an even divisor set by a parameter. It idles low. Outgoing bits change on its falling edge and incoming bits are taken on its rising edge.

Top module: `ser_ctl_master`

## Requirements
- R1: While `rst` is high and after it, until a request is taken: `cs_n`=1, `sck`=0, `mosi`=0, `busy`=0, `done`=0.
- R2: A request (`req_valid`=1) is accepted only while `busy`=0. `busy` rises in the cycle after acceptance and falls in the same cycle that `cs_n` returns high. Requests presented while `busy`=1 are ignored and start no frame.
- R3: After a request is accepted, `cs_n` stays high for as long as `dreq`=0. `cs_n` falls on the first clock edge at which `dreq` is sampled high.
- R4: Each chip-select window contains exactly 32 rising edges of `sck`. `sck` is 0 whenever `cs_n`=1. Each high phase and each low phase of `sck` lasts SCK_DIV/2 system clocks.
- R5: A write frame on `mosi` is the opcode 8'h02, then the address, then the write word. Every field goes most significant bit first.
- R6: A read frame on `mosi` is the opcode 8'h03, then the address, then sixteen 0 bits.
- R7: `mosi` changes only while `sck` is low, so it is steady across every rising edge. `miso` is sampled on the rising edges of `sck`.
- R8: The first rising edge of `sck` follows the fall of `cs_n` by exactly SCK_DIV system clocks. `cs_n` rises SCK_DIV/2 system clocks after the last falling edge of `sck`.
- R9: `done` is high for exactly one cycle, in the cycle `cs_n` rises. For a read, `rd_data` in that cycle holds the 16 bits sampled on `miso` at rising edges 17 to 32, first-sampled bit in bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write word |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with `done` |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to codec |
| miso | input | 1 | Serial data from codec |
| dreq | input | 1 | Codec ready (1) / executing (0) |

## Verification
The bench writes to and reads from all 256 addresses, and a codec model returns an address-derived word on each read. A design that swapped the opcodes, reversed the bit order or put an extra setup tick at the start of the frame would show a wrong 32-bit frame or an edge count other than 32. A design that sampled `miso` one edge off would return a shifted read word. Timing counters measure the chip-select setup, the tail after the last edge and every `sck` phase, so a miscounted divider shows up as a timing mismatch. Separate cases hold `dreq` low for a long stretch and send a second request in the middle of a frame. A design that ignored the ready line would open the window early, and one that queued the extra request would produce an extra frame.

// File: rtl/scictl_pkg.sv
package scictl_pkg;

    localparam int OPC_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = OPC_W + ADDR_W + WORD_W;

    localparam logic [OPC_W-1:0] OPC_WRITE = 8'h02;
    localparam logic [OPC_W-1:0] OPC_READ  = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } ctl_state_e;

    typedef struct packed {
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } ctl_cmd_t;

    function automatic logic [FRAME_W-1:0] build_frame(ctl_cmd_t c);
        logic [OPC_W-1:0]  opc;
        logic [WORD_W-1:0] body;
        opc  = c.is_read ? OPC_READ : OPC_WRITE;
        body = c.is_read ? '0 : c.wdata;
        return {opc, c.addr, body};
    endfunction

endpackage

// File: rtl/scictl_tick.sv
module scictl_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scictl_shift.sv
module scictl_shift
    import scictl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               tx_step,
    input  logic               rx_step,
    input  logic               miso,
    output logic               mosi,
    output logic [WORD_W-1:0]  rx_word
);
    logic [FRAME_W-1:0] tx_q;
    logic [WORD_W-1:0]  rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= frame_in;
        end else if (tx_step) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= '0;
        end else if (rx_step) begin
            rx_q <= {rx_q[WORD_W-2:0], miso};
        end
    end

    assign mosi    = tx_q[FRAME_W-1];
    assign rx_word = rx_q;

endmodule

// File: rtl/ser_ctl_master.sv
module ser_ctl_master
    import scictl_pkg::*;
#(
    parameter int SCK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    input  logic        dreq
);
    localparam int HALF  = SCK_DIV / 2;
    localparam int TICKS = 2 * FRAME_W + 2;
    localparam int TCW   = $clog2(TICKS + 1);
    localparam logic [TCW-1:0] LAST_T = TCW'(TICKS - 1);

    ctl_state_e       st;
    ctl_cmd_t         cmd;
    logic [TCW-1:0]   tcnt;
    logic             tick;
    logic             load;
    logic             last_t;
    logic             rise_t;
    logic             fall_t;
    logic [WORD_W-1:0] rx_word;

    assign last_t = tick && (tcnt == LAST_T);
    assign rise_t = tick && tcnt[0] && !last_t;
    assign fall_t = tick && !tcnt[0] && (tcnt != '0);
    assign load   = (st == ST_WAIT) && dreq;
    assign busy   = (st != ST_IDLE);

    scictl_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (st == ST_XFER),
        .tick (tick)
    );

    scictl_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .frame_in (build_frame(cmd)),
        .tx_step  (fall_t && (st == ST_XFER)),
        .rx_step  (rise_t && (st == ST_XFER)),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cmd     <= '0;
            tcnt    <= '0;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cmd <= '{is_read: req_read, addr: req_addr, wdata: req_wdata};
                        st  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dreq) begin
                        cs_n <= 1'b0;
                        tcnt <= '0;
                        st   <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (tick) begin
                        tcnt <= tcnt + 1'b1;
                        if (last_t) begin
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                            rd_data <= rx_word;
                            st      <= ST_IDLE;
                        end else if (rise_t) begin
                            sck <= 1'b1;
                        end else if (fall_t) begin
                            sck <= 1'b0;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    initial begin
        assert (SCK_DIV >= 2 && SCK_DIV % 2 == 0)
            else $error("SCK_DIV must be even and at least 2");
    end

    assert_cs_gate_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> $past(dreq));

    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    assert_mosi_steady_R7: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    assert_done_at_close_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(cs_n));

    assert_busy_covers_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

endmodule

// File: tb/ser_ctl_master_bench.sv
module ser_ctl_master_bench;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, cs_n, sck, mosi;
    logic [15:0] rd_data;
    logic        miso = 1'b0;
    logic        dreq = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(negedge clk) cyc++;

    ser_ctl_master #(.SCK_DIV(DIV)) u_ser_ctl_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
        .dreq(dreq)
    );

    // codec model and timing monitor
    logic [31:0] mon_bits;
    logic [15:0] reply = '0;
    int mon_rises = 0, frames = 0, phase_err = 0, glitch = 0;
    int t_cs_fall = 0, t_first_rise = 0, t_last_rise = 0, t_last_fall = 0, t_cs_rise = 0;
    bit in_frame = 1'b0;

    always @(negedge cs_n) begin
        in_frame  = 1'b1;
        mon_rises = 0;
        mon_bits  = '0;
        t_cs_fall = cyc;
        miso      = 1'b0;
    end

    always @(posedge sck) if (cs_n === 1'b0) begin
        if (mon_rises == 0) t_first_rise = cyc;
        else if (cyc - t_last_fall != HALF) phase_err++;
        t_last_rise = cyc;
        mon_bits = {mon_bits[30:0], mosi};
        mon_rises++;
    end

    always @(negedge sck) if (cs_n === 1'b0) begin
        if (cyc - t_last_rise != HALF) phase_err++;
        t_last_fall = cyc;
        if (mon_rises >= 16 && mon_rises < 32) miso = reply[31 - mon_rises];
        else miso = 1'b0;
    end

    always @(posedge cs_n) if (in_frame) begin
        in_frame  = 1'b0;
        t_cs_rise = cyc;
        frames++;
    end

    always @(mosi) if (cs_n === 1'b0 && sck === 1'b1) glitch++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_txn(input bit rd, input logic [7:0] a, input logic [15:0] w,
                           input logic [15:0] rep, input int hold);
        logic [31:0] exp_frame;
        int n;
        reply = rep;
        exp_frame = rd ? {8'h03, a, 16'h0000} : {8'h02, a, w};
        if (hold > 0) dreq = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (hold > 0) begin
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                if (cs_n !== 1'b1) check(0, "R3 cs_n held while dreq low", cs_n, 1);
            end
            check(cs_n == 1'b1, "R3 cs_n high while dreq low", cs_n, 1);
            dreq = 1'b1;
            @(negedge clk);
            check(cs_n == 1'b0, "R3 cs_n falls once dreq high", cs_n, 0);
        end
        n = 0;
        while (done !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, "R9 done seen", done, 1);
        check(cs_n == 1'b1, "R9 cs_n high with done", cs_n, 1);
        check(busy == 1'b0, "R2 busy low at close", busy, 0);
        if (rd) check(rd_data == rep, "R9 read word", rd_data, rep);
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", done, 0);
        check(mon_rises == 32, "R4 rising edge count", mon_rises, 32);
        check(phase_err == 0, "R4 sck phase length", phase_err, 0);
        if (rd) check(mon_bits == exp_frame, "R6 read frame", mon_bits, exp_frame);
        else    check(mon_bits == exp_frame, "R5 write frame", mon_bits, exp_frame);
        check(glitch == 0, "R7 mosi steady while sck high", glitch, 0);
        check(t_first_rise - t_cs_fall == DIV, "R8 setup", t_first_rise - t_cs_fall, DIV);
        check(t_cs_rise - t_last_fall == HALF, "R8 tail", t_cs_rise - t_last_fall, HALF);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL R2 watchdog expired actual=%0d expected=done", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        check(cs_n == 1 && sck == 0 && mosi == 0 && busy == 0 && done == 0,
              "R1 state in reset", {cs_n, sck, mosi, busy, done}, 5'b10000);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(cs_n == 1 && sck == 0 && busy == 0 && done == 0,
              "R1 idle after reset", {cs_n, sck, busy, done}, 4'b1000);

        for (int a = 0; a < 256; a++)
            run_txn(1'b0, a[7:0], (16'(a) * 16'h0101) ^ 16'h5A3C, 16'h0000, 0);
        for (int a = 0; a < 256; a++)
            run_txn(1'b1, a[7:0], 16'hFFFF, {~a[7:0], a[7:0]} ^ 16'h0F0F, 0);

        run_txn(1'b1, 8'h0B, 16'h0000, 16'h8001, 37);
        run_txn(1'b0, 8'hC4, 16'hBEEF, 16'h0000, 5);

        // request during a frame must be dropped
        fork
            run_txn(1'b0, 8'h21, 16'h1234, 16'h0000, 0);
            begin
                repeat (30) @(negedge clk);
                req_valid = 1'b1; req_read = 1'b1; req_addr = 8'h99;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        f0 = frames;
        repeat (300) @(negedge clk);
        check(frames == f0, "R2 request while busy ignored", frames, f0);
        check(busy == 1'b0 && cs_n == 1'b1, "R2 idle after ignored request", {busy, cs_n}, 2'b01);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule